// File: doc/BRIEF.md
# ADC Conversion Step Sequencer

The sequencer runs a pass over sixteen programmable conversion steps and drives an external successive-approximation converter through a start/done handshake. Each step carries its own input line, settling wait, sample-hold width and averaging count. For every enabled step the block waits out the settling time and holds the start strobe for the sample width. It collects a power-of-two number of conversions and averages them with a shift. The averaged value, tagged with the step number, goes into a small result queue.

In touchscreen mode each pass opens with a charge interval of programmable length. The pen-up input is sampled at the end of that interval. If the pen has lifted, every step marked as a touch step is dropped for the rest of the pass, while the general channel steps still run. A pass either ends in idle or wraps back to step 0, depending on the continuous-mode input.

Top module: `adc_step_seq`

## Requirements
- R1: Each pass visits steps in ascending order, and every enabled step yields exactly one result. A disabled step yields none and costs no settling or sample time.
- R2: A step configuration word has these fields: bit 35 enable, bit 34 touch flag, bits 33:31 input line (0 to 7), bits 30:13 open delay, bits 12:5 sample width, bits 4:0 averaging count. `adc_chan` carries the line of the active step.
- R3: With touch mode off and step 0 enabled, `adc_start` first goes high on rising edge open+3, counting the edge that samples `run` as edge 1.
- R4: `adc_start` stays high for exactly max(sample width, 1) cycles for each conversion. Repeat conversions of a step do not repeat the open delay.
- R5: Averaging counts of 1, 2, 4, 8 and 16 take that many conversions; any other value takes one. The result is the sum shifted right by log2 of the count, truncated.
- R6: A result word holds the step number in bits 15:12 and the 12-bit average in bits 11:0. Results are read from a 16-entry first-in first-out queue whose head is visible while `res_valid` is high and is removed by `res_pop`.
- R7: With touch mode on, `charge_on` is high for max(`charge_len`, 1) cycles at the start of each pass. `adc_start` is never high in those cycles.
- R8: `pen_up` is sampled in the last charge cycle. If it is high, touch-flagged steps are skipped for that pass, `pen_up_evt` pulses for one cycle, and general steps still produce results.
- R9: A result produced while the queue holds 16 entries is dropped and sets `res_ovf`, which stays set until reset.
- R10: In one-shot mode `busy` falls after the last enabled step of the pass. In continuous mode step 0 follows step 15 in a new pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Step configuration write strobe |
| cfg_addr | input | 4 | Step number to write |
| cfg_wdata | input | 36 | Step configuration word (R2 layout) |
| run | input | 1 | Starts a pass when idle |
| continuous | input | 1 | 1: wrap to a new pass, 0: stop after one |
| touch_en | input | 1 | Enables the charge interval and pen-up check |
| charge_len | input | 16 | Charge interval length in cycles |
| pen_up | input | 1 | Pen-up detector level |
| adc_start | output | 1 | Start-of-conversion strobe |
| adc_chan | output | 3 | Input line of the active step |
| adc_done | input | 1 | Conversion complete pulse |
| adc_data | input | 12 | Conversion value, valid with adc_done |
| charge_on | output | 1 | Charge interval active |
| pen_up_evt | output | 1 | One-cycle pen-up event pulse |
| busy | output | 1 | A pass is in progress |
| res_valid | output | 1 | Queue holds at least one result |
| res_data | output | 16 | Queue head: step number and average |
| res_pop | input | 1 | Removes the queue head |
| res_ovf | output | 1 | Sticky result-drop flag |

## Verification
The main function is tried with a sparse step set that has mixed lines and averaging counts of 1, 2, 4 and 16. This pattern separates correct step ordering and skipping from wrong shift amounts and miscounted conversions, because the converter model returns values that vary per conversion. A touch pattern is run twice, once with the pen down and once with it up. These two runs show whether the charge length and the pen-up abort hit only touch-flagged steps. A continuous two-step pattern at steps 14 and 15 checks the wrap order. A free-running single step with no reader checks the queue limit and the drop flag. Separate delay patterns compare the first strobe edge and the strobe width against the open delay and the sample width, including a sample width of zero.

// File: rtl/adc_seq_pkg.sv
// Shared types for the step sequencer: step configuration layout and FSM states.
package adc_seq_pkg;
    localparam int CH_W   = 3;
    localparam int OPEN_W = 18;
    localparam int SAMP_W = 8;
    localparam int AVG_W  = 5;
    localparam int DATA_W = 12;

    // One step's configuration; field order fixes the write-word layout.
    typedef struct packed {
        logic              en;
        logic              touch;
        logic [CH_W-1:0]   chan;
        logic [OPEN_W-1:0] open_dly;
        logic [SAMP_W-1:0] samp_dly;
        logic [AVG_W-1:0]  avg;
    } step_cfg_t;

    localparam int CFG_W = $bits(step_cfg_t);

    typedef enum logic [2:0] {
        S_IDLE, S_CHARGE, S_SEEK, S_OPEN, S_SAMPLE, S_WAIT, S_STORE
    } seq_state_t;

    // Shift amount for an averaging count; unsupported counts mean one sample.
    function automatic logic [2:0] avg_shift(input logic [AVG_W-1:0] n);
        case (n)
            5'd2:    return 3'd1;
            5'd4:    return 3'd2;
            5'd8:    return 3'd3;
            5'd16:   return 3'd4;
            default: return 3'd0;
        endcase
    endfunction
endpackage

// File: rtl/step_regfile.sv
// Step configuration storage. One write port, all steps readable in parallel.
// Assumes writes happen while the sequencer is idle; reset disables every step.
module step_regfile import adc_seq_pkg::*; #(
    parameter int NUM_STEPS = 16,
    localparam int STEP_W = $clog2(NUM_STEPS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [STEP_W-1:0]         waddr,
    input  logic [CFG_W-1:0]          wdata,
    output logic [NUM_STEPS*CFG_W-1:0] cfg_flat
);
    logic [CFG_W-1:0] mem [NUM_STEPS];

    // Store a configuration word, or clear all words on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_STEPS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NUM_STEPS; g++) begin : g_out
        assign cfg_flat[g*CFG_W +: CFG_W] = mem[g];
    end
endmodule

// File: rtl/step_accum.sv
// Conversion accumulator. Cleared when a step is selected, adds each finished
// conversion, and presents the sum shifted by the step's averaging exponent.
module step_accum #(
    parameter int DATA_W = 12,
    parameter int ACC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              add,
    input  logic [DATA_W-1:0] data,
    input  logic [2:0]        shift,
    output logic [DATA_W-1:0] avg
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] shifted;

    // Hold the running sum of the current step's conversions.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) acc <= '0;
        else if (add)        acc <= acc + ACC_W'(data);
    end

    assign shifted = acc >> shift;
    assign avg     = shifted[DATA_W-1:0];
endmodule

// File: rtl/result_fifo.sv
// Show-ahead result queue. A push while full is dropped and sets a sticky flag.
module result_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic             valid,
    output logic [WIDTH-1:0] dout,
    output logic             ovf
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt;
    logic             full, do_push, do_pop;

    assign full    = (cnt == CNT_W'(DEPTH));
    assign valid   = (cnt != '0);
    assign do_push = push && !full;
    assign do_pop  = pop && valid;
    assign dout    = mem[rp];

    // Store accepted results.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Advance pointers and occupancy; latch the drop flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0; rp <= '0; cnt <= '0; ovf <= 1'b0;
        end else begin
            if (do_push) wp <= (wp == PTR_W'(DEPTH-1)) ? '0 : wp + PTR_W'(1);
            if (do_pop)  rp <= (rp == PTR_W'(DEPTH-1)) ? '0 : rp + PTR_W'(1);
            if (do_push && !do_pop)      cnt <= cnt + CNT_W'(1);
            else if (do_pop && !do_push) cnt <= cnt - CNT_W'(1);
            if (push && full) ovf <= 1'b1;
        end
    end

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));
    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
endmodule

// File: rtl/adc_step_seq.sv
// Conversion step sequencer top. Walks the enabled steps, optionally after a
// touchscreen charge interval with pen-up check, drives the converter handshake
// and queues averaged, step-tagged results. Assumes adc_done arrives only after
// adc_start has fallen and that configuration changes only while idle.
module adc_step_seq import adc_seq_pkg::*; #(
    parameter int NUM_STEPS  = 16,
    parameter int CHG_W      = 16,
    parameter int ACC_W      = 16,
    parameter int FIFO_DEPTH = 16,
    localparam int STEP_W = $clog2(NUM_STEPS),
    localparam int RES_W  = STEP_W + DATA_W,
    localparam int CNT_W  = (OPEN_W > CHG_W) ? OPEN_W : CHG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [STEP_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              run,
    input  logic              continuous,
    input  logic              touch_en,
    input  logic [CHG_W-1:0]  charge_len,
    input  logic              pen_up,
    output logic              adc_start,
    output logic [CH_W-1:0]   adc_chan,
    input  logic              adc_done,
    input  logic [DATA_W-1:0] adc_data,
    output logic              charge_on,
    output logic              pen_up_evt,
    output logic              busy,
    output logic              res_valid,
    output logic [RES_W-1:0]  res_data,
    input  logic              res_pop,
    output logic              res_ovf
);
    seq_state_t                  state;
    logic [STEP_W:0]             idx;
    logic [STEP_W-1:0]           cur, fsel;
    logic [CNT_W-1:0]            cnt;
    logic [AVG_W-1:0]            nconv;
    logic                        skip_touch, found;
    logic [NUM_STEPS*CFG_W-1:0]  cfg_flat;
    step_cfg_t                   cfg [NUM_STEPS];
    logic [NUM_STEPS-1:0]        elig;
    step_cfg_t                   cc;
    logic [2:0]                  sh;
    logic [CNT_W-1:0]            samp_len, chg_start;
    logic [DATA_W-1:0]           avg_val;
    logic                        res_push;

    step_regfile #(.NUM_STEPS(NUM_STEPS)) i_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr),
        .wdata(cfg_wdata), .cfg_flat(cfg_flat));

    for (genvar g = 0; g < NUM_STEPS; g++) begin : g_dec
        assign cfg[g]  = step_cfg_t'(cfg_flat[g*CFG_W +: CFG_W]);
        assign elig[g] = cfg[g].en && !(cfg[g].touch && skip_touch);
    end

    // Pick the lowest eligible step at or above the scan index.
    always_comb begin
        found = 1'b0;
        fsel  = '0;
        for (int i = NUM_STEPS - 1; i >= 0; i--) begin
            if (elig[i] && (i >= int'(idx))) begin
                found = 1'b1;
                fsel  = STEP_W'(i);
            end
        end
    end

    assign cc        = cfg[cur];
    assign sh        = avg_shift(cc.avg);
    assign samp_len  = (cc.samp_dly == '0) ? CNT_W'(1) : CNT_W'(cc.samp_dly);
    assign chg_start = (charge_len == '0) ? CNT_W'(1) : CNT_W'(charge_len);
    assign adc_start = (state == S_SAMPLE);
    assign adc_chan  = cc.chan;
    assign charge_on = (state == S_CHARGE);
    assign busy      = (state != S_IDLE);
    assign res_push  = (state == S_STORE);

    // Main sequencing: charge, step selection, delays, conversions, store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE; idx <= '0; cur <= '0; cnt <= '0;
            nconv <= '0; skip_touch <= 1'b0; pen_up_evt <= 1'b0;
        end else begin
            pen_up_evt <= 1'b0;
            case (state)
                S_IDLE: if (run) begin
                    idx <= '0; skip_touch <= 1'b0; cnt <= chg_start;
                    state <= touch_en ? S_CHARGE : S_SEEK;
                end
                S_CHARGE: begin
                    if (cnt == CNT_W'(1)) begin
                        skip_touch <= pen_up;
                        pen_up_evt <= pen_up;
                        state      <= S_SEEK;
                    end else cnt <= cnt - CNT_W'(1);
                end
                S_SEEK: begin
                    if (found) begin
                        cur   <= fsel;
                        cnt   <= CNT_W'(cfg[fsel].open_dly);
                        nconv <= '0;
                        state <= S_OPEN;
                    end else if (continuous) begin
                        idx <= '0; skip_touch <= 1'b0; cnt <= chg_start;
                        state <= touch_en ? S_CHARGE : S_SEEK;
                    end else state <= S_IDLE;
                end
                S_OPEN: begin
                    if (cnt == '0) begin
                        cnt   <= samp_len;
                        state <= S_SAMPLE;
                    end else cnt <= cnt - CNT_W'(1);
                end
                S_SAMPLE: begin
                    if (cnt == CNT_W'(1)) state <= S_WAIT;
                    else cnt <= cnt - CNT_W'(1);
                end
                S_WAIT: if (adc_done) begin
                    if (nconv == AVG_W'((1 << sh) - 1)) state <= S_STORE;
                    else begin
                        nconv <= nconv + AVG_W'(1);
                        cnt   <= samp_len;
                        state <= S_SAMPLE;
                    end
                end
                S_STORE: begin
                    idx   <= {1'b0, cur} + (STEP_W+1)'(1);
                    state <= S_SEEK;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    step_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) i_acc (
        .clk(clk), .rst_n(rst_n), .clear(state == S_SEEK),
        .add((state == S_WAIT) && adc_done), .data(adc_data),
        .shift(sh), .avg(avg_val));

    result_fifo #(.WIDTH(RES_W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n), .push(res_push), .din({cur, avg_val}),
        .pop(res_pop), .valid(res_valid), .dout(res_data), .ovf(res_ovf));

    // R7
    charge_start_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(adc_start && charge_on));
    // R1
    push_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_push |-> cfg[cur].en);
    // R8
    pen_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_push && skip_touch) |-> !cfg[cur].touch);
    // R8
    pen_evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pen_up_evt |=> !pen_up_evt);
endmodule

// File: tb/test_adc_step_seq.sv
`timescale 1ns/1ps
module test_adc_step_seq;
    logic        clk = 0, rst_n = 0;
    logic        cfg_we = 0;
    logic [3:0]  cfg_addr = '0;
    logic [35:0] cfg_wdata = '0;
    logic        run = 0, continuous = 0, touch_en = 0, pen_up = 0;
    logic [15:0] charge_len = '0;
    logic        adc_start, adc_done = 0, charge_on, pen_up_evt, busy;
    logic [2:0]  adc_chan;
    logic [11:0] adc_data = '0;
    logic        res_valid, res_ovf;
    logic [15:0] res_data;
    logic        mon_pop = 0, man_pop = 0, mon_en = 1;

    int checks = 0, fails = 0;
    int g = 0, g_exp = 0, popped = 0;
    int cur_w = 0, last_w = 0, chg_cnt = 0, pen_cnt = 0;
    logic [15:0] q [$];

    always #4 clk = ~clk;

    adc_step_seq i_adc_step_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .run(run), .continuous(continuous),
        .touch_en(touch_en), .charge_len(charge_len), .pen_up(pen_up),
        .adc_start(adc_start), .adc_chan(adc_chan), .adc_done(adc_done),
        .adc_data(adc_data), .charge_on(charge_on), .pen_up_evt(pen_up_evt),
        .busy(busy), .res_valid(res_valid), .res_data(res_data),
        .res_pop(mon_pop | man_pop), .res_ovf(res_ovf));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Converter model: answers each strobe two cycles after it falls.
    logic       prev_start = 0;
    int         dly = 0;
    logic [2:0] ch_lat = '0;
    always @(negedge clk) begin
        adc_done = 0;
        if (prev_start && !adc_start) begin dly = 2; ch_lat = adc_chan; end
        else if (dly > 0) begin
            dly--;
            if (dly == 0) begin
                adc_done = 1;
                adc_data = 12'(int'(ch_lat) * 400 + (g % 8) * 7);
                g++;
            end
        end
        prev_start = adc_start;
        if (adc_start) cur_w++;
        else if (cur_w > 0) begin last_w = cur_w; cur_w = 0; end
        if (charge_on) chg_cnt++;
        if (pen_up_evt) pen_cnt++;
    end

    // Scoreboard monitor: compares the queue head with the expected item.
    always @(negedge clk) begin
        if (mon_pop) mon_pop = 0;
        else if (mon_en && res_valid) begin
            if (q.size() == 0) chk(0, "R1 unexpected result", int'(res_data), -1);
            else begin
                logic [15:0] e;
                e = q.pop_front();
                chk(res_data == e, "R5 R6 result word", int'(res_data), int'(e));
            end
            popped++;
            mon_pop = 1;
        end
    end

    function automatic int shf(input int av);
        case (av) 2: return 1; 4: return 2; 8: return 3; 16: return 4; default: return 0; endcase
    endfunction

    // Driver side: predicts one step's result and queues it.
    task automatic exp_step(input int i, input int ch, input int av);
        int n, s;
        n = 1 << shf(av); s = 0;
        for (int k = 0; k < n; k++) s += ch * 400 + ((g_exp + k) % 8) * 7;
        g_exp += n;
        q.push_back({4'(i), 12'(s >> shf(av))});
    endtask

    task automatic wr_step(input int i, input bit en, input bit t, input int ch,
                           input int od, input int sd, input int av);
        @(negedge clk);
        cfg_we = 1; cfg_addr = 4'(i);
        cfg_wdata = {en, t, 3'(ch), 18'(od), 8'(sd), 5'(av)};
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic clear_steps();
        for (int i = 0; i < 16; i++) wr_step(i, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic pulse_run();
        @(negedge clk); run = 1;
        @(negedge clk); run = 0;
    endtask

    task automatic wait_idle();
        int t = 0;
        @(negedge clk);
        while (busy && t < 20000) begin @(negedge clk); t++; end
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (20000 * 8) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n, p0, c0, e0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R6 R9 R10 reset state
        chk(!res_valid, "R6 reset empty", res_valid, 0);
        chk(!adc_start, "R4 reset strobe", adc_start, 0);
        chk(!busy, "R10 reset idle", busy, 0);
        chk(!res_ovf, "R9 reset flag", res_ovf, 0);

        // R1 R2 R5 R10: sparse one-shot pass, mixed lines and averaging
        wr_step(1, 1, 0, 2, 3, 2, 2);
        wr_step(3, 1, 0, 5, 0, 1, 16);
        wr_step(4, 0, 0, 6, 9, 9, 4);
        wr_step(7, 1, 0, 7, 1, 3, 4);
        wr_step(15, 1, 0, 1, 2, 1, 3);
        exp_step(1, 2, 2); exp_step(3, 5, 16); exp_step(7, 7, 4); exp_step(15, 1, 3);
        p0 = popped;
        pulse_run();
        wait_idle();
        chk(popped - p0 == 4, "R1 result count", popped - p0, 4);
        chk(q.size() == 0, "R1 missing results", q.size(), 0);
        chk(!busy, "R10 one-shot ends idle", busy, 0);

        // R3: first strobe edge versus open delay
        clear_steps();
        wr_step(0, 1, 0, 4, 5, 1, 1);
        exp_step(0, 4, 1);
        n = 0;
        @(negedge clk); run = 1;
        while (n < 100) begin
            @(posedge clk); n++;
            @(negedge clk); run = 0;
            if (adc_start) break;
        end
        chk(n == 8, "R3 open delay latency", n, 8);
        wait_idle();

        // R4: strobe width, including a zero sample width
        wr_step(0, 1, 0, 3, 0, 7, 2);
        exp_step(0, 3, 2);
        pulse_run(); wait_idle();
        chk(last_w == 7, "R4 sample width", last_w, 7);
        wr_step(0, 1, 0, 3, 0, 0, 1);
        exp_step(0, 3, 1);
        pulse_run(); wait_idle();
        chk(last_w == 1, "R4 zero sample width", last_w, 1);

        // R7 R8: touch pass with pen down, then with pen up
        clear_steps();
        wr_step(0, 1, 1, 1, 2, 1, 2);
        wr_step(1, 1, 1, 2, 0, 2, 1);
        wr_step(2, 1, 0, 5, 1, 1, 4);
        touch_en = 1; charge_len = 16'd10; pen_up = 0;
        exp_step(0, 1, 2); exp_step(1, 2, 1); exp_step(2, 5, 4);
        p0 = popped; c0 = chg_cnt; e0 = pen_cnt;
        pulse_run(); wait_idle();
        chk(chg_cnt - c0 == 10, "R7 charge length", chg_cnt - c0, 10);
        chk(popped - p0 == 3, "R8 pen down results", popped - p0, 3);
        chk(pen_cnt == e0, "R8 no pen event", pen_cnt - e0, 0);
        pen_up = 1;
        exp_step(2, 5, 4);
        p0 = popped; e0 = pen_cnt;
        pulse_run(); wait_idle();
        chk(popped - p0 == 1, "R8 touch steps skipped", popped - p0, 1);
        chk(pen_cnt - e0 == 1, "R8 pen event pulse", pen_cnt - e0, 1);
        chk(q.size() == 0, "R8 general step kept", q.size(), 0);
        touch_en = 0; pen_up = 0;

        // R10: continuous wrap over steps 14 and 15
        clear_steps();
        wr_step(14, 1, 0, 6, 0, 1, 2);
        wr_step(15, 1, 0, 7, 0, 1, 1);
        for (int k = 0; k < 6; k++) begin exp_step(14, 6, 2); exp_step(15, 7, 1); end
        p0 = popped; continuous = 1;
        pulse_run();
        n = 0;
        while (popped - p0 < 4 && n < 5000) begin @(negedge clk); n++; end
        continuous = 0;
        wait_idle();
        chk(popped - p0 >= 4, "R10 continuous wrap", popped - p0, 4);
        q.delete();
        g_exp = g;

        // R9: unread queue fills and the drop flag latches
        clear_steps();
        mon_en = 0;
        wr_step(0, 1, 0, 3, 0, 1, 1);
        continuous = 1;
        pulse_run();
        n = 0;
        while (!res_ovf && n < 5000) begin @(negedge clk); n++; end
        continuous = 0;
        wait_idle();
        chk(res_ovf, "R9 overflow flag", res_ovf, 1);
        n = 0;
        while (res_valid && n < 40) begin
            chk(res_data[15:12] == 4'd0, "R6 step tag", res_data[15:12], 0);
            man_pop = 1; @(negedge clk); man_pop = 0; @(negedge clk); n++;
        end
        chk(n == 16, "R9 queue depth", n, 16);
        chk(res_ovf, "R9 flag sticky", res_ovf, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule